// File: doc/BRIEF.md
# Threshold-Triggered Receive Burst FIFO

A 32-dword staging FIFO between a receive-side loader and a bus-master burst engine. The loader pushes dwords through a ready/valid write port. The drain side asks for the bus and empties the FIFO in bursts of one dword per granted cycle. A burst starts in one of two cases: the fill level reaches a programmable quarter-step threshold, or the last dword of the current copy has been loaded.

Each copy is announced with a byte count, which the block rounds up to whole dwords. When that many dwords have been pushed, a flush is pending and the bus is requested even if the level is below threshold. A burst ends when the FIFO runs dry or when the grant is withdrawn. If the grant is withdrawn while the level still meets the threshold, or a flush is still pending, the request stays up and the block waits for the next grant. Loading may continue during a burst. A write to a full FIFO is held off and never dropped.

Top module: `rx_burst_fifo`

## Requirements
- R1: After reset, `bus_req`, `burst_act` and `rd_valid` are low, `wr_ready` is high, and the threshold select holds 01.
- R2: Threshold select encodings are 00 = 8 dwords, 01 = 16, 10 = 24, 11 = 32. `bus_req` rises one cycle after the edge on which the level first equals the selected count.
- R3: While the level is below threshold and no flush is pending, `bus_req` stays low.
- R4: When the final dword of a copy is pushed, `bus_req` rises one cycle later, whatever the threshold.
- R5: A copy of N bytes ends after ceil(N/4) dword pushes (13 bytes gives 4 dwords, 12 bytes gives 3).
- R6: While `bus_req` is high, it stays high until a grant is seen. The edge that sees `bus_gnt` with the request up starts a burst. In a burst, each cycle with `bus_gnt` high moves one dword out (`rd_valid` high), in the order written.
- R7: A burst lasts until the FIFO is empty. On the cycle after the last dword leaves, `bus_req` and `burst_act` are low.
- R8: If `bus_gnt` drops during a burst while the level is at or above threshold, then on the next cycle `burst_act` is low and `bus_req` is still high.
- R9: If `bus_gnt` drops during a burst while the level is below threshold and no flush is pending, then on the next cycle `bus_req` is low.
- R10: Writes are accepted while a burst is draining, and every accepted dword is delivered exactly once.
- R11: With 32 dwords held, `wr_ready` is low and a waiting write is kept, not lost, until space frees up.
- R12: A pulse on `cfg_we` loads `cfg_thr` into the threshold select on that edge, and the new threshold applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load new threshold select |
| cfg_thr | input | 2 | Threshold select value |
| copy_start | input | 1 | Begin a copy of `copy_bytes` bytes |
| copy_bytes | input | 16 | Byte count of the copy |
| wr_valid | input | 1 | Write data offered |
| wr_data | input | 32 | Write dword |
| wr_ready | output | 1 | FIFO can take a dword |
| bus_gnt | input | 1 | Bus granted to drain side |
| bus_req | output | 1 | Bus request |
| burst_act | output | 1 | Burst in progress |
| rd_valid | output | 1 | A dword is transferred this cycle |
| rd_data | output | 32 | Head dword of the FIFO |

## Verification
The request is due one clock after the edge that brings the level to threshold or pushes the last dword of a copy. The bench samples at the falling edge before that point and again one cycle later, so early and late requests both fail a check. Burst start, grant-loss reactions and end-of-burst drops are each checked one full cycle after the edge where the grant changes or the FIFO empties. Transferred dwords are compared at the falling edge on which `rd_valid` is high, against a queue of accepted writes kept in the bench.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2
  } bdf_state_e;

  // Quarter-step fill level in dwords for a select code.
  function automatic int unsigned thr_dwords(input logic [1:0] sel, input int unsigned depth);
    return ((int'(sel) + 1) * depth) / 4;
  endfunction

  // Byte count rounded up to whole dwords.
  function automatic logic [31:0] bytes_to_dwords(input logic [31:0] nbytes);
    logic [32:0] sum;
    sum = {1'b0, nbytes} + 33'd3;
    return sum[33-1:2] & 32'h3FFF_FFFF;
  endfunction

endpackage

// File: rtl/bdf_store.sv
module bdf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign rd_data = mem[rptr];
  assign full    = (level == LVL_W'(DEPTH));

  // R11: a full FIFO is not pushed, and without a pop it stays full (nothing dropped)
  a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !push);
  a_r11_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) && !pop |=> (level == LVL_W'(DEPTH)));
  // R10: never read from an empty store
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !pop);

endmodule

// File: rtl/bdf_copy_track.sv
module bdf_copy_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy_start,
  input  logic [CNT_W-1:0] copy_bytes,
  input  logic             push,
  output logic             copy_done
);

  logic [CNT_W-1:0] remaining;
  logic             active;
  logic [CNT_W-1:0] start_dw;

  assign start_dw  = CNT_W'(bdf_pkg::bytes_to_dwords(32'(copy_bytes)));
  assign copy_done = active && push && (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      active    <= 1'b0;
    end else if (copy_start) begin
      remaining <= start_dw;
      active    <= (start_dw != '0);
    end else if (active && push) begin
      remaining <= remaining - CNT_W'(1);
      if (remaining == CNT_W'(1)) active <= 1'b0;
    end
  end

  // R5: a copy ends on a push and only while one is running
  a_r5_done_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> push);
  a_r5_done_ends_copy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done && !copy_start |=> !copy_done);

endmodule

// File: rtl/bdf_burst_ctrl.sv
module bdf_burst_ctrl #(
  parameter int DEPTH  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       thr_sel,
  input  logic [LVL_W-1:0] level,
  input  logic             push,
  input  logic             copy_done,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             burst_act,
  output logic             pop
);
  import bdf_pkg::*;

  bdf_state_e       state, state_nxt;
  logic             flush_pend;
  logic [LVL_W-1:0] thr_lvl, lvl_nxt;
  logic             at_thr, nxt_at_thr;
  logic             drained_evt, gnt_lost_evt, flush_clr;

  assign thr_lvl      = LVL_W'(thr_dwords(thr_sel, DEPTH));
  assign at_thr       = (level >= thr_lvl);
  assign pop          = (state == ST_BURST) && bus_gnt && (level != '0);
  assign lvl_nxt      = level + LVL_W'(push) - LVL_W'(pop);
  assign nxt_at_thr   = (lvl_nxt >= thr_lvl);
  assign drained_evt  = pop && (lvl_nxt == '0);
  assign gnt_lost_evt = (state == ST_BURST) && !bus_gnt;
  assign flush_clr    = drained_evt || ((state == ST_IDLE) && (level == '0) && !push);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if ((at_thr || flush_pend) && (level != '0)) state_nxt = ST_REQ;
      ST_REQ:   if (bus_gnt) state_nxt = ST_BURST;
      ST_BURST: begin
        if (drained_evt || (level == '0 && !push)) state_nxt = ST_IDLE;
        else if (gnt_lost_evt) state_nxt = (nxt_at_thr || flush_pend) ? ST_REQ : ST_IDLE;
      end
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      flush_pend <= 1'b0;
    end else begin
      state <= state_nxt;
      if (copy_done)      flush_pend <= 1'b1;
      else if (flush_clr) flush_pend <= 1'b0;
    end
  end

  assign bus_req   = (state != ST_IDLE);
  assign burst_act = (state == ST_BURST);

  // R2: reaching the threshold while idle raises the request next cycle
  a_r2_thr_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && at_thr && (level != '0) |=> bus_req);
  // R4: a pending end-of-copy flush raises the request below threshold
  a_r4_flush_request: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend && !burst_act && (level != '0) |=> bus_req);
  // R6: a request is held until granted
  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !burst_act && !bus_gnt |=> bus_req);
  // R7: emptying ends the burst and drops the request
  a_r7_end_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    drained_evt |=> !bus_req && !burst_act);
  // R8: grant lost at or above threshold keeps the request
  a_r8_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_lost_evt && nxt_at_thr |=> bus_req && !burst_act);
  // R9: grant lost below threshold with no flush drops the request
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_lost_evt && !nxt_at_thr && !flush_pend && !copy_done |=> !bus_req);

endmodule

// File: rtl/rx_burst_fifo.sv
module rx_burst_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_thr,
  input  logic              copy_start,
  input  logic [CNT_W-1:0]  copy_bytes,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              burst_act,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0]       thr_sel;
  logic             push, pop, full, copy_done;
  logic [LVL_W-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_sel <= 2'b01;
    else if (cfg_we) thr_sel <= cfg_thr;
  end

  assign wr_ready = !full;
  assign push     = wr_valid && wr_ready;
  assign rd_valid = pop;

  bdf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .wr_data (wr_data),
    .pop     (pop),
    .rd_data (rd_data),
    .level   (level),
    .full    (full)
  );

  bdf_copy_track #(.CNT_W(CNT_W)) u_copy (
    .clk        (clk),
    .rst_n      (rst_n),
    .copy_start (copy_start),
    .copy_bytes (copy_bytes),
    .push       (push),
    .copy_done  (copy_done)
  );

  bdf_burst_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_sel   (thr_sel),
    .level     (level),
    .push      (push),
    .copy_done (copy_done),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .burst_act (burst_act),
    .pop       (pop)
  );

  // R6: data only moves inside a granted burst
  a_r6_move_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> burst_act && bus_gnt);
  // R12: a threshold write takes effect on its edge
  a_r12_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (thr_sel == $past(cfg_thr)));

endmodule

// File: tb/test_rx_burst_fifo.sv
module test_rx_burst_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_thr = 2'b00;
  logic        copy_start = 1'b0;
  logic [15:0] copy_bytes = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        bus_gnt = 1'b0;
  logic        bus_req, burst_act, rd_valid;
  logic [31:0] rd_data;

  int unsigned n_chk = 0, n_bad = 0, n_pop = 0;
  logic [31:0] exp_q [$];
  logic [31:0] seq = 32'hA000_0000;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_burst_fifo i_rx_burst_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .copy_start(copy_start), .copy_bytes(copy_bytes),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .burst_act(burst_act),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6/R10: every transferred dword must match the oldest accepted write
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_pop++;
      if (exp_q.size() == 0) chk(1'b0, "R6 pop from empty model", 1, 0);
      else begin
        chk(rd_data == exp_q[0], "R6 data order", int'(rd_data), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic wr_one();
    wr_valid = 1'b1;
    wr_data  = seq;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back(seq);
    seq = seq + 32'd1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_n(input int n);
    for (int i = 0; i < n; i++) wr_one();
  endtask

  task automatic set_thr(input logic [1:0] s);
    cfg_we = 1'b1; cfg_thr = s;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_copy(input int nbytes);
    copy_start = 1'b1; copy_bytes = 16'(nbytes);
    @(posedge clk); @(negedge clk);
    copy_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Grant until the model queue is empty, then check the request has dropped.
  task automatic drain(input string req);
    int guard = 0;
    bus_gnt = 1'b1;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(guard < 2000, {req, " drain timeout"}, guard, 0);
    chk(!bus_req && !burst_act, {req, " req/burst low after empty"}, int'(bus_req), 0);
  endtask

  task automatic t_reset();
    chk(!bus_req, "R1 bus_req", int'(bus_req), 0);
    chk(!burst_act, "R1 burst_act", int'(burst_act), 0);
    chk(!rd_valid, "R1 rd_valid", int'(rd_valid), 0);
    chk(wr_ready, "R1 wr_ready", int'(wr_ready), 1);
    // default select 01: 15 dwords give no request, the 16th does
    wr_n(15);
    idle(2);
    chk(!bus_req, "R1 default threshold not at 15", int'(bus_req), 0);
    wr_one();
    chk(!bus_req, "R2 request not before its cycle", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req, "R1 default threshold 16", int'(bus_req), 1);
    drain("R7");
  endtask

  task automatic t_threshold(input logic [1:0] s);
    int lvl = (int'(s) + 1) * 8;
    set_thr(s);
    wr_n(lvl - 1);
    idle(3);
    chk(!bus_req, "R3 below threshold", int'(bus_req), 0);
    wr_one();
    chk(!bus_req, "R2 not early", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req, "R2 request at threshold", int'(bus_req), 1);
    chk(!burst_act, "R6 no burst before grant", int'(burst_act), 0);
    idle(3);
    chk(bus_req, "R6 request held until grant", int'(bus_req), 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk(burst_act, "R6 burst after grant", int'(burst_act), 1);
    chk(rd_valid, "R6 first transfer", int'(rd_valid), 1);
    drain("R7");
  endtask

  task automatic t_copy(input int nbytes, input int ndw);
    set_thr(2'b01);
    start_copy(nbytes);
    wr_n(ndw - 1);
    idle(3);
    chk(!bus_req, "R5 no flush before last dword", int'(bus_req), 0);
    wr_one();
    @(negedge clk);
    chk(bus_req, "R4 flush request below threshold", int'(bus_req), 1);
    n_pop = 0;
    drain("R7");
    chk(n_pop == ndw, "R5 dwords in copy", int'(n_pop), ndw);
  endtask

  task automatic t_loss_high();
    set_thr(2'b00);
    wr_n(20);
    bus_gnt = 1'b1;
    idle(4);
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(!burst_act, "R8 burst stops on grant loss", int'(burst_act), 0);
    chk(bus_req, "R8 request kept above threshold", int'(bus_req), 1);
    drain("R7");
  endtask

  task automatic t_loss_low();
    set_thr(2'b11);
    wr_n(32);
    bus_gnt = 1'b1;
    idle(5);
    bus_gnt = 1'b0;
    @(negedge clk);
    chk(!bus_req && !burst_act, "R9 request dropped below threshold", int'(bus_req), 0);
    idle(3);
    chk(!bus_req, "R3 stays idle below threshold", int'(bus_req), 0);
    set_thr(2'b00);
    chk(!bus_req, "R12 not before next cycle", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req, "R12 new threshold applies", int'(bus_req), 1);
    drain("R7");
  endtask

  task automatic t_full();
    set_thr(2'b11);
    wr_n(32);
    wr_valid = 1'b1;
    wr_data  = seq;
    chk(!wr_ready, "R11 ready low when full", int'(wr_ready), 0);
    idle(3);
    chk(!wr_ready, "R11 still stalled", int'(wr_ready), 0);
    n_pop = 0;
    bus_gnt = 1'b1;
    wr_one();
    drain("R11");
    chk(n_pop == 33, "R11 stalled write delivered", int'(n_pop), 33);
  endtask

  task automatic t_load_during_burst();
    int ok_rdy = 1;
    set_thr(2'b00);
    wr_n(16);
    n_pop = 0;
    bus_gnt = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      if (!wr_ready) ok_rdy = 0;
      wr_one();
    end
    chk(ok_rdy == 1, "R10 writes accepted during burst", ok_rdy, 1);
    drain("R10");
    chk(n_pop == 20, "R10 all dwords delivered", int'(n_pop), 20);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold(2'b00);
    t_threshold(2'b01);
    t_threshold(2'b10);
    t_threshold(2'b11);
    t_copy(13, 4);
    t_copy(12, 3);
    t_loss_high();
    t_loss_low();
    t_full();
    t_load_during_burst();
    chk(exp_q.size() == 0, "R10 nothing left over", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule